// File: doc/BRIEF.md
# Misaligned Transfer Bus Splitter

This block turns one logical transfer of byte, word or longword size, at any byte address, into a short series of naturally aligned accesses on a 32-bit bus. A misaligned word becomes two byte accesses. A misaligned longword becomes either word-word or byte-word-byte, depending on its offset, so it never degrades into four byte accesses. Each access carries its address, its access size and the byte-lane enables for the four lanes. The block steps to the next access only when the bus returns ready.

A transfer source and a transfer destination each use their own instance. Requests arrive on a valid/ready handshake. `req_ready` is high only while the block is idle, so a request is taken when `req_valid` and `req_ready` are both high at a clock edge. While a transfer is in progress, further requests are held off by back-pressure. On the bus side `bus_valid` is the request and `bus_ready` the acknowledge. The bus may stall for any number of cycles, and the offered access is held steady while it does. A one-cycle `done` marks completion. `acc_count` reports how many accesses the current transfer needs.

Top module: `misaligned_splitter`

## Requirements
- R1: Size code 0 (byte), and the reserved code 3, always produce exactly one byte access (bus_size 0) at the request address. Its lane enable is the single bit at position addr modulo 4.
- R2: Size code 1 (word) at an even address produces one word access (bus_size 1). At an odd address it produces two byte accesses.
- R3: Size code 2 (longword) at an address that is a multiple of 4 produces one longword access (bus_size 2) with lane enables 4'b1111.
- R4: A longword at an odd address produces three accesses, in the order byte, word, byte.
- R5: A longword at an address of the form 4n+2 produces two word accesses.
- R6: The accesses of a transfer go in increasing address order. Each starts at the byte after the previous one ends, with addresses wrapping modulo 2^ADDR_W. Each is aligned to its own size, and its lane enables cover exactly its bytes.
- R7: The next access is offered only after the current one is acknowledged with bus_ready. While bus_ready is low, bus_addr, bus_size and bus_lanes hold steady.
- R8: `done` is high for exactly one cycle. That cycle is the one in which the final access is acknowledged.
- R9: `acc_count` is 0 after reset. When a request is taken it becomes the number of accesses (1, 2 or 3) and holds until the next request is taken.
- R10: `req_ready` is high only while no transfer is in progress. A request presented during a transfer has no effect on the accesses produced.
- R11: After reset `bus_valid` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the logical transfer |
| req_size | input | 2 | Transfer size: 0 byte, 1 word, 2 longword, 3 treated as byte |
| bus_valid | output | 1 | An access is being offered |
| bus_ready | input | 1 | Bus acknowledges the offered access |
| bus_addr | output | ADDR_W | Address of the offered access |
| bus_size | output | 2 | Access size: 0 byte, 1 word, 2 longword |
| bus_lanes | output | 4 | Byte-lane enables, bit k for address modulo 4 equal to k |
| done | output | 1 | Final access acknowledged this cycle |
| acc_count | output | 2 | Number of accesses in the current transfer |

## Verification
The bench builds the block with ADDR_W set to 16. At that width, transfers that begin in the last bytes of the address space are cheap to reach, so the carry out of the low bits and the wrap back to address zero between sub-accesses are both exercised. All sizes are driven at all four offsets, under a bus that is always ready and under a pseudo-random stalling bus. The stalling case brings the hold rules within reach, and so do requests intruding while a transfer is in progress.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

  localparam int LANES     = 4;
  localparam int MAX_STEPS = 3;
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);
  localparam int STEP_W    = $clog2(MAX_STEPS);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [CNT_W-1:0]              count;
    logic [MAX_STEPS-1:0][1:0]     steps;
  } split_plan_t;

  function automatic logic [2:0] size_bytes(logic [1:0] s);
    case (s)
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/split_planner.sv
module split_planner
  import splitter_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [1:0]  offs,
  output split_plan_t plan
);

  always_comb begin
    plan       = '0;
    plan.count = CNT_W'(1);
    case (acc_size_e'(size))
      SZ_WORD: begin
        if (offs[0]) begin
          plan.count    = CNT_W'(2);
          plan.steps[0] = SZ_BYTE;
          plan.steps[1] = SZ_BYTE;
        end else begin
          plan.steps[0] = SZ_WORD;
        end
      end
      SZ_LONG: begin
        case (offs)
          2'd0: plan.steps[0] = SZ_LONG;
          2'd2: begin
            plan.count    = CNT_W'(2);
            plan.steps[0] = SZ_WORD;
            plan.steps[1] = SZ_WORD;
          end
          default: begin
            plan.count    = CNT_W'(3);
            plan.steps[0] = SZ_BYTE;
            plan.steps[1] = SZ_WORD;
            plan.steps[2] = SZ_BYTE;
          end
        endcase
      end
      default: plan.steps[0] = SZ_BYTE;
    endcase
  end

endmodule

// File: rtl/split_lane_decode.sv
module split_lane_decode
  import splitter_pkg::*;
(
  input  logic [1:0]       offs,
  input  logic [1:0]       size,
  output logic [LANES-1:0] lanes
);

  logic [2:0] nbytes;
  logic [3:0] lo;
  logic [3:0] hi;

  always_comb begin
    nbytes = size_bytes(size);
    lo     = {2'b00, offs};
    hi     = lo + {1'b0, nbytes};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes[i] = (4'(i) >= lo) && (4'(i) < hi);
  end

endmodule

// File: rtl/split_seq.sv
module split_seq
  import splitter_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  split_plan_t       plan,
  input  logic              ack,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        cur_size,
  output logic              last,
  output logic [CNT_W-1:0]  count
);

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [STEP_W-1:0] step_q;
  split_plan_t       plan_q;
  logic [ADDR_W-1:0] incr;

  always_comb begin
    cur_size = plan_q.steps[step_q];
    last     = (CNT_W'(step_q) + CNT_W'(1)) == plan_q.count;
    incr     = ADDR_W'(size_bytes(cur_size));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      step_q <= '0;
      plan_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      addr_q <= start_addr;
      step_q <= '0;
      plan_q <= plan;
    end else if (busy_q && ack) begin
      addr_q <= addr_q + incr;
      if (last) busy_q <= 1'b0;
      else      step_q <= step_q + STEP_W'(1);
    end
  end

  assign busy     = busy_q;
  assign cur_addr = addr_q;
  assign count    = plan_q.count;

endmodule

// File: rtl/misaligned_splitter.sv
module misaligned_splitter
  import splitter_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [LANES-1:0]  bus_lanes,
  output logic              done,
  output logic [CNT_W-1:0]  acc_count
);

  split_plan_t plan;
  logic        busy;
  logic        last;
  logic        take;

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;

  split_planner u_plan (
    .size (req_size),
    .offs (req_addr[1:0]),
    .plan (plan)
  );

  split_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take),
    .start_addr (req_addr),
    .plan       (plan),
    .ack        (bus_ready),
    .busy       (busy),
    .cur_addr   (bus_addr),
    .cur_size   (bus_size),
    .last       (last),
    .count      (acc_count)
  );

  split_lane_decode u_lanes (
    .offs  (bus_addr[1:0]),
    .size  (bus_size),
    .lanes (bus_lanes)
  );

  assign bus_valid = busy;
  assign done      = busy && bus_ready && last;

endmodule

// File: rtl/split_checker.sv
module split_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [3:0]        bus_lanes,
  input logic              done,
  input logic [1:0]        acc_count
);

  logic [ADDR_W-1:0] next_addr;
  assign next_addr = bus_addr + ((bus_size == 2'd2) ? ADDR_W'(4) :
                                 (bus_size == 2'd1) ? ADDR_W'(2) : ADDR_W'(1));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_size) && $stable(bus_lanes)));

  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_valid && bus_ready));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !done) |=> (bus_valid && bus_addr == $past(next_addr)));

  p_align_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size == 2'd1) |-> !bus_addr[0]);

  p_align_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size == 2'd2) |-> (bus_addr[1:0] == 2'd0 && bus_lanes == 4'hF));

  p_lane_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones(bus_lanes) == ((bus_size == 2'd2) ? 4 : (bus_size == 2'd1) ? 2 : 1)));

  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (acc_count != 2'd0));

endmodule

bind misaligned_splitter split_checker #(.ADDR_W(ADDR_W)) u_split_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_lanes (bus_lanes),
  .done      (done),
  .acc_count (acc_count)
);

// File: tb/tb_misaligned_splitter.sv
`timescale 1ns/1ps
module tb_misaligned_splitter;

  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic              bus_valid;
  logic              bus_ready = 1'b1;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic [3:0]        bus_lanes;
  logic              done;
  logic [1:0]        acc_count;

  misaligned_splitter #(.ADDR_W(ADDR_W)) dut (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [1:0]        s;
    logic [3:0]        l;
    bit                last;
  } exp_t;

  exp_t q[$];
  int   vecs = 0;
  int   errs = 0;
  bit   stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus acknowledge pattern
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_ready = stall_mode ? (lfsr[0] & ~lfsr[2]) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_valid) begin
        chk(!req_ready, "R10", "req_ready while busy", req_ready, 0);
        if (q.size() == 0) begin
          chk(0, "R7", "unexpected access addr", bus_addr, 0);
        end else begin
          chk(bus_addr  == q[0].a, "R6", "access addr", bus_addr, q[0].a);
          chk(bus_size  == q[0].s, "R2", "access size", bus_size, q[0].s);
          chk(bus_lanes == q[0].l, "R1", "lane enables", bus_lanes, q[0].l);
          if (bus_ready) begin
            chk(done == q[0].last, "R8", "done at ack", done, q[0].last);
            void'(q.pop_front());
          end else begin
            chk(done == 1'b0, "R7", "done while stalled", done, 0);
          end
        end
      end else if (done) begin
        chk(0, "R8", "done without access", done, 0);
      end
    end
  end

  // expected sequence: largest aligned piece that fits the remaining bytes
  task automatic run_xfer(logic [ADDR_W-1:0] addr, logic [1:0] size, bit intrude, string tag);
    int n;
    int cnt;
    logic [ADDR_W-1:0] a;
    n   = (size == 2'd2) ? 4 : (size == 2'd1) ? 2 : 1;
    a   = addr;
    cnt = 0;
    while (n > 0) begin
      exp_t e;
      int   s;
      if (n >= 4 && a[1:0] == 2'd0)      s = 4;
      else if (n >= 2 && a[0] == 1'b0)   s = 2;
      else                               s = 1;
      e.a    = a;
      e.s    = (s == 4) ? 2'd2 : (s == 2) ? 2'd1 : 2'd0;
      e.l    = 4'(((1 << s) - 1) << a[1:0]);
      n      = n - s;
      e.last = (n == 0);
      q.push_back(e);
      a   = a + ADDR_W'(s);
      cnt++;
    end
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = addr;
    req_size  = size;
    @(posedge clk); #1;
    if (intrude) begin
      req_addr = addr ^ 16'h0135;
      req_size = 2'd2;
      repeat (2) @(posedge clk);
      #1;
    end
    req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(acc_count == 2'(cnt), "R9", {tag, " access count"}, acc_count, cnt);
    chk(req_ready == 1'b1, "R10", {tag, " ready after done"}, req_ready, 1);
    chk(bus_valid == 1'b0, "R8", {tag, " idle after done"}, bus_valid, 0);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);
    chk(bus_valid == 1'b0, "R11", "reset bus_valid", bus_valid, 0);
    chk(done == 1'b0, "R11", "reset done", done, 0);
    chk(acc_count == 2'd0, "R9", "reset count", acc_count, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    for (int sm = 0; sm < 2; sm++) begin
      stall_mode = sm[0];
      for (int off = 0; off < 4; off++) begin
        run_xfer(ADDR_W'(16'h0100 + off), 2'd0, 0, "R1 byte");
        run_xfer(ADDR_W'(16'h0200 + off), 2'd1, 0, "R2 word");
        run_xfer(ADDR_W'(16'h0300 + off), 2'd2, 0, "R3 R4 R5 long");
        run_xfer(ADDR_W'(16'h0400 + off), 2'd3, 0, "R1 reserved");
      end
      run_xfer(16'hFFFD, 2'd2, 0, "R6 wrap long");
      run_xfer(16'hFFFF, 2'd1, 0, "R6 wrap word");
      run_xfer(16'h1233, 2'd2, 1, "R10 intrude long");
      run_xfer(16'h2342, 2'd2, 1, "R5 intrude");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule